// File: doc/BRIEF.md
# Variable-Slot Retire Control Unit

This block keeps program order for an out-of-order core. When an instruction is dispatched, it claims a run of adjacent slots in a circular queue. The length of the run depends on how many micro-operations the instruction has. The block hands back a token, which is the number of the first slot in that run. The execution side later reports completion by presenting that token.

On every clock the block looks at the oldest entries. It releases, in program order, those that have completed, and it stops at the first entry that has not. On a separate output lane it reports the caller's instruction index for each entry it releases.

The queue size comes from two parameters. A nonzero reorder-buffer size wins; otherwise the micro-op buffer size is used. A cap parameter limits how many entries may leave the queue per cycle, where zero means "as many as there are output lanes".

Reservation is a valid/ready handshake. `resv_ready` depends only on registered state and on `resv_uops`. A caller that sees it low must hold its request. The retire stream is a group of lanes sharing one ready: valid lanes are always contiguous from lane 0. Either all presented lanes are accepted together (`ret_ready` high) or none are, and while `ret_ready` is low the presented lane 0 holds its value.

Top module: `retire_ctrl`

## Requirements
- R1: After a synchronous reset the queue is empty: no retire lane is valid, `resv_ready` is high for any request, and the token offered is 0.
- R2: A request reserves max(1, min(micro-ops, capacity)) slots: a zero-micro-op request takes one slot, and an oversize one takes the whole queue.
- R3: `resv_token` always shows the current tail slot number. An accepted request moves the tail forward by its slot count, wrapping modulo the capacity.
- R4: `resv_ready` is high exactly when the requested slot count does not exceed the free slots. Slots released by retirement count as free only from the following cycle.
- R5: Presenting a token on the executed port marks that entry complete. An entry is never retired before it is marked, and an unmarked oldest entry blocks all younger ones.
- R6: Retired entries come out in program order on lanes 0, 1, 2… with no gaps, each lane carrying its instruction index (lane k in bits k*IDX_W upward of `ret_idx`).
- R7: At most MAX_RETIRE entries retire per cycle. With MAX_RETIRE = 0 the limit is RET_LANES.
- R8: While `ret_ready` is low nothing retires, and the presented lane 0 entry stays on the port.
- R9: Retiring an entry returns its slot count to the free pool and moves the head forward by that count, modulo the capacity.
- R10: Capacity equals ROB_SIZE when that is nonzero, otherwise UOP_BUF_SIZE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| resv_valid | input | 1 | Reservation request |
| resv_ready | output | 1 | Enough free slots for the current request |
| resv_idx | input | IDX_W | Instruction index stored with the entry |
| resv_uops | input | UOP_W | Micro-op count of the request |
| resv_token | output | SLOT_W | Tail slot number, the token for an accepted request |
| exec_valid | input | 1 | Completion report |
| exec_token | input | SLOT_W | Token of the completed entry |
| ret_valid | output | RET_LANES | Per-lane retire valid, contiguous from lane 0 |
| ret_idx | output | RET_LANES*IDX_W | Per-lane retired instruction index |
| ret_ready | input | 1 | Accept all presented retire lanes this cycle |

## Verification
The bench covers several corner cases.
- Zero-micro-op and oversize requests. A design that skipped the clamp or the floor of one would hand out the wrong next token, or refuse a full-queue request.
- Tail wrap. An off-by-one in the modulo step would show up as a token past the end of the queue.
- A head entry left unmarked while younger entries are complete. A design that scanned past incomplete entries would retire out of order.
- The per-cycle cap, checked both with a limit and with the unlimited setting on a smaller queue. A design that ignored the cap would show too many lanes, and one that ignored the override would accept more slots than the queue has.
- Back-pressure. A design that retired while the consumer stalled would drop indices.
- The full-queue cycle in which a release happens. If freed slots were granted in that same cycle, `resv_ready` would rise one cycle early.

// File: rtl/retire_ctrl_pkg.sv
package retire_ctrl_pkg;

  // Modular add for a ring whose size need not be a power of two.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned size);
    int unsigned s;
    s = a + b;
    if (s >= size) s = s - size;
    return s;
  endfunction

  // Slot count for a request: floor of one, ceiling of the queue size.
  function automatic int unsigned slot_need(int unsigned uops, int unsigned size);
    int unsigned n;
    n = (uops > size) ? size : uops;
    if (n == 0) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/retire_alloc.sv
module retire_alloc
  import retire_ctrl_pkg::*;
#(
  parameter int CAP    = 8,
  parameter int UOP_W  = 4,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resv_valid,
  input  logic [UOP_W-1:0]  resv_uops,
  output logic              resv_ready,
  output logic              resv_fire,
  output logic [SLOT_W-1:0] tail,
  output logic [CNT_W-1:0]  need,
  output logic [CNT_W-1:0]  free_cnt,
  input  logic              rel_fire,
  input  logic [CNT_W-1:0]  rel_slots
);

  logic [SLOT_W-1:0] tail_q;
  logic [CNT_W-1:0]  free_q;

  always_comb begin
    need       = CNT_W'(slot_need(int'(unsigned'(resv_uops)), CAP));
    resv_ready = (need <= free_q);
    resv_fire  = resv_valid && resv_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '0;
      free_q <= CNT_W'(CAP);
    end else begin
      if (resv_fire)
        tail_q <= SLOT_W'(ring_add(int'(unsigned'(tail_q)), int'(unsigned'(need)), CAP));
      free_q <= free_q - (resv_fire ? need : '0) + (rel_fire ? rel_slots : '0);
    end
  end

  assign tail     = tail_q;
  assign free_cnt = free_q;

  assert_free_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    int'(unsigned'(free_q)) <= CAP);

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
    resv_fire |-> (need != '0) && (int'(unsigned'(need)) <= CAP));

endmodule

// File: rtl/retire_store.sv
module retire_store #(
  parameter int CAP    = 8,
  parameter int IDX_W  = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CNT_W-1:0]  wr_need,
  input  logic              exec_valid,
  input  logic [SLOT_W-1:0] exec_token,
  output logic [IDX_W-1:0]  ent_idx  [CAP],
  output logic [CNT_W-1:0]  ent_need [CAP],
  output logic [CAP-1:0]    ent_done
);

  logic [IDX_W-1:0] idx_q  [CAP];
  logic [CNT_W-1:0] need_q [CAP];
  logic [CAP-1:0]   done_q;

  genvar g;
  generate
    for (g = 0; g < CAP; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && (int'(unsigned'(wr_slot)) == g)) begin
          idx_q[g]  <= wr_idx;
          need_q[g] <= wr_need;
        end
      end

      always_ff @(posedge clk) begin
        if (rst)
          done_q[g] <= 1'b0;
        else if (wr_en && (int'(unsigned'(wr_slot)) == g))
          done_q[g] <= 1'b0;
        else if (exec_valid && (int'(unsigned'(exec_token)) == g))
          done_q[g] <= 1'b1;
      end

      assign ent_idx[g]  = idx_q[g];
      assign ent_need[g] = need_q[g];
    end
  endgenerate

  assign ent_done = done_q;

  assert_exec_legal_R5: assert property (@(posedge clk) disable iff (rst)
    exec_valid |-> (int'(unsigned'(exec_token)) < CAP) && !done_q[exec_token]);

endmodule

// File: rtl/retire_select.sv
module retire_select
  import retire_ctrl_pkg::*;
#(
  parameter int CAP       = 8,
  parameter int IDX_W     = 8,
  parameter int SLOT_W    = 3,
  parameter int CNT_W     = 4,
  parameter int RET_LANES = 4,
  parameter int LIMIT     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           ent_idx  [CAP],
  input  logic [CNT_W-1:0]           ent_need [CAP],
  input  logic [CAP-1:0]             ent_done,
  input  logic [CNT_W-1:0]           free_cnt,
  input  logic                       ret_ready,
  output logic [RET_LANES-1:0]       ret_valid,
  output logic [RET_LANES*IDX_W-1:0] ret_idx,
  output logic                       rel_fire,
  output logic [CNT_W-1:0]           rel_slots
);

  logic [SLOT_W-1:0] head_q, head_n;
  int unsigned       used;

  always_comb begin
    int unsigned p;
    int unsigned acc;
    logic        run;
    p         = int'(unsigned'(head_q));
    acc       = 0;
    run       = 1'b1;
    used      = CAP - int'(unsigned'(free_cnt));
    ret_valid = '0;
    ret_idx   = '0;
    for (int k = 0; k < RET_LANES; k++) begin
      if (run && (k < LIMIT) && (acc < used) && ent_done[SLOT_W'(p)]) begin
        ret_valid[k]                = 1'b1;
        ret_idx[k*IDX_W +: IDX_W]   = ent_idx[SLOT_W'(p)];
        acc = acc + int'(unsigned'(ent_need[SLOT_W'(p)]));
        p   = ring_add(p, int'(unsigned'(ent_need[SLOT_W'(p)])), CAP);
      end else begin
        run = 1'b0;
      end
    end
    head_n    = SLOT_W'(p);
    rel_slots = CNT_W'(acc);
    rel_fire  = ret_ready && ret_valid[0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      head_q <= '0;
    else if (rel_fire)
      head_q <= head_n;
  end

  assert_lanes_packed_R6: assert property (@(posedge clk) disable iff (rst)
    ((ret_valid + 1'b1) & ret_valid) == '0);

  assert_retire_cap_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(ret_valid) <= LIMIT);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_valid[0] && !ret_ready) |=> (ret_valid[0] && $stable(ret_idx[IDX_W-1:0])));

  assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(unsigned'(free_cnt)) == CAP) |-> (ret_valid == '0));

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
  parameter int UOP_BUF_SIZE = 8,
  parameter int ROB_SIZE     = 0,
  parameter int IDX_W        = 8,
  parameter int UOP_W        = 4,
  parameter int RET_LANES    = 4,
  parameter int MAX_RETIRE   = 2,
  localparam int CAP    = (ROB_SIZE != 0) ? ROB_SIZE : UOP_BUF_SIZE,
  localparam int SLOT_W = (CAP > 1) ? $clog2(CAP) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       resv_valid,
  output logic                       resv_ready,
  input  logic [IDX_W-1:0]           resv_idx,
  input  logic [UOP_W-1:0]           resv_uops,
  output logic [SLOT_W-1:0]          resv_token,
  input  logic                       exec_valid,
  input  logic [SLOT_W-1:0]          exec_token,
  output logic [RET_LANES-1:0]       ret_valid,
  output logic [RET_LANES*IDX_W-1:0] ret_idx,
  input  logic                       ret_ready
);

  localparam int CNT_W = $clog2(CAP + 1);
  localparam int LIMIT = (MAX_RETIRE == 0 || MAX_RETIRE > RET_LANES) ? RET_LANES : MAX_RETIRE;

  logic              resv_fire, rel_fire;
  logic [SLOT_W-1:0] tail;
  logic [CNT_W-1:0]  need, free_cnt, rel_slots;
  logic [IDX_W-1:0]  ent_idx  [CAP];
  logic [CNT_W-1:0]  ent_need [CAP];
  logic [CAP-1:0]    ent_done;

  retire_alloc #(.CAP(CAP), .UOP_W(UOP_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_alloc (
    .clk(clk), .rst(rst),
    .resv_valid(resv_valid), .resv_uops(resv_uops), .resv_ready(resv_ready),
    .resv_fire(resv_fire), .tail(tail), .need(need), .free_cnt(free_cnt),
    .rel_fire(rel_fire), .rel_slots(rel_slots)
  );

  retire_store #(.CAP(CAP), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(resv_fire), .wr_slot(tail), .wr_idx(resv_idx), .wr_need(need),
    .exec_valid(exec_valid), .exec_token(exec_token),
    .ent_idx(ent_idx), .ent_need(ent_need), .ent_done(ent_done)
  );

  retire_select #(.CAP(CAP), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
                  .RET_LANES(RET_LANES), .LIMIT(LIMIT)) u_select (
    .clk(clk), .rst(rst),
    .ent_idx(ent_idx), .ent_need(ent_need), .ent_done(ent_done),
    .free_cnt(free_cnt), .ret_ready(ret_ready),
    .ret_valid(ret_valid), .ret_idx(ret_idx),
    .rel_fire(rel_fire), .rel_slots(rel_slots)
  );

  assign resv_token = tail;

  assert_capacity_R10: assert property (@(posedge clk) disable iff (rst)
    int'(unsigned'(resv_token)) < CAP);

endmodule

// File: tb/sim_retire_ctrl.sv
module sim_retire_ctrl;
  logic clk = 1'b0;
  logic rst0, rst1;
  logic resv_valid, exec_valid, ret_ready;
  logic [7:0] resv_idx;
  logic [3:0] resv_uops;
  logic [2:0] exec_token;
  logic r0_ready, r1_ready;
  logic [2:0] r0_token, r1_token;
  logic [3:0] r0_vld, r1_vld;
  logic [31:0] r0_idx, r1_idx;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  retire_ctrl u0 (
    .clk(clk), .rst(rst0), .resv_valid(resv_valid), .resv_ready(r0_ready),
    .resv_idx(resv_idx), .resv_uops(resv_uops), .resv_token(r0_token),
    .exec_valid(exec_valid), .exec_token(exec_token),
    .ret_valid(r0_vld), .ret_idx(r0_idx), .ret_ready(ret_ready));

  retire_ctrl #(.UOP_BUF_SIZE(8), .ROB_SIZE(6), .MAX_RETIRE(0)) u1 (
    .clk(clk), .rst(rst1), .resv_valid(resv_valid), .resv_ready(r1_ready),
    .resv_idx(resv_idx), .resv_uops(resv_uops), .resv_token(r1_token),
    .exec_valid(exec_valid), .exec_token(exec_token),
    .ret_valid(r1_vld), .ret_idx(r1_idx), .ret_ready(ret_ready));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nxt;
    @(negedge clk);
    #2;
  endtask

  task automatic idle;
    resv_valid = 1'b0; exec_valid = 1'b0; ret_ready = 1'b1;
    resv_idx = '0; resv_uops = '0; exec_token = '0;
  endtask

  task automatic resv(int idx, int uops);
    resv_valid = 1'b1; resv_idx = 8'(idx); resv_uops = 4'(uops);
  endtask

  task automatic mark(int tok);
    exec_valid = 1'b1; exec_token = 3'(tok);
  endtask

  task automatic t_reset;
    rst0 = 1'b1; rst1 = 1'b1; idle();
    nxt(); nxt();
    rst0 = 1'b0;
    #1;
    chk("R1 ready", int'(r0_ready), 1);
    chk("R1 token", int'(r0_token), 0);
    chk("R1 valid", int'(r0_vld), 0);
    nxt();
  endtask

  task automatic t_reserve;
    resv(10, 0); #1 chk("R2 token zero-uop", int'(r0_token), 0); nxt();
    resv(11, 3); #1 chk("R3 token after 1-slot", int'(r0_token), 1); nxt();
    resv(12, 2); #1 chk("R3 token after 3-slot", int'(r0_token), 4); nxt();
    resv_valid = 1'b0; resv_uops = 4'd3;
    #1 chk("R3 tail", int'(r0_token), 6);
    chk("R4 short of space", int'(r0_ready), 0);
    resv_uops = 4'd2;
    #1 chk("R4 exact fit", int'(r0_ready), 1);
    nxt();
  endtask

  task automatic t_order;
    mark(4); nxt(); exec_valid = 1'b0;
    #1 chk("R5 head blocks", int'(r0_vld), 0);
    mark(0); ret_ready = 1'b0; nxt(); exec_valid = 1'b0;
    #1 chk("R6 lane0 valid", int'(r0_vld), 1);
    chk("R6 lane0 idx", int'(r0_idx[7:0]), 10);
    mark(1); nxt(); exec_valid = 1'b0;
    #1 chk("R7 capped lanes", int'(r0_vld), 3);
    chk("R8 held idx", int'(r0_idx[7:0]), 10);
    chk("R6 lane1 idx", int'(r0_idx[15:8]), 11);
    ret_ready = 1'b1; nxt();
    #1 chk("R9 remaining", int'(r0_vld), 1);
    chk("R9 head moved", int'(r0_idx[7:0]), 12);
    nxt();
    #1 chk("R9 drained", int'(r0_vld), 0);
    resv_uops = 4'd15;
    #1 chk("R2 clamp fits empty", int'(r0_ready), 1);
    nxt();
  endtask

  task automatic t_wrap;
    resv(20, 4); #1 chk("R3 token at 6", int'(r0_token), 6); nxt();
    resv_valid = 1'b0;
    #1 chk("R3 wrapped tail", int'(r0_token), 2);
    mark(6); nxt(); exec_valid = 1'b0;
    #1 chk("R6 wrapped entry", int'(r0_idx[7:0]), 20);
    chk("R5 marked retires", int'(r0_vld), 1);
    nxt();
  endtask

  task automatic t_full;
    resv(30, 8); #1 chk("R3 full token", int'(r0_token), 2); nxt();
    resv_valid = 1'b0; resv_uops = 4'd0;
    #1 chk("R4 full", int'(r0_ready), 0);
    mark(2); nxt(); exec_valid = 1'b0;
    resv(31, 0);
    #1 chk("R4 not same cycle", int'(r0_ready), 0);
    chk("R6 full entry", int'(r0_idx[7:0]), 30);
    nxt();
    #1 chk("R4 next cycle", int'(r0_ready), 1);
    chk("R9 token", int'(r0_token), 2);
    nxt();
    idle();
  endtask

  task automatic t_unlimited;
    rst0 = 1'b1; rst1 = 1'b1; idle(); nxt(); rst0 = 1'b0; rst1 = 1'b0;
    resv(40, 15); #1 chk("R10 token", int'(r1_token), 0); nxt();
    resv_valid = 1'b0; resv_uops = 4'd0;
    #1 chk("R10 six slots full", int'(r1_ready), 0);
    chk("R10 tail wrapped", int'(r1_token), 0);
    mark(0); nxt(); exec_valid = 1'b0;
    #1 chk("R6 u1 idx", int'(r1_idx[7:0]), 40);
    nxt();
    ret_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin resv(50 + i, 0); nxt(); end
    resv_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin mark(i); nxt(); end
    exec_valid = 1'b0;
    #1 chk("R7 unlimited lanes", int'(r1_vld), 15);
    chk("R7 lane3 idx", int'(r1_idx[31:24]), 53);
    chk("R7 capped u0", int'(r0_vld), 3);
    ret_ready = 1'b1; nxt();
    #1 chk("R7 u1 drained", int'(r1_vld), 0);
    chk("R7 u0 rest", int'(r0_idx[15:0]), 53 * 256 + 52);
    nxt();
  endtask

  initial begin
    t_reset();
    t_reserve();
    t_order();
    t_wrap();
    t_full();
    t_unlimited();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule